// File: doc/BRIEF.md
# Predicated Vector Element Step Skipper

This block sits between a predicate-mask producer and the issue controller of a vector loop. It keeps two element step counters, one for the source operand and one for the destination operand, and compares them against a vector length supplied by the controller. When the controller asks it to prepare an element, it waits for a source mask and a destination mask to arrive over a valid/ready handshake.

On accepting the masks, each operand independently looks for the lowest enabled element at or above its current step, capped at the vector length. If either counter moves, the block tells the controller to go back and re-decode with the new stepping state. If neither moves, it offers the current element for execution over a second valid/ready handshake. Zeroing mode on an operand and scalar (non-vector) operation both leave the counters untouched. The controller can load both counters while the block is idle.

Top module: `predicated_step_skipper`

## Requirements
- R1: `mask_ready_o` is high in every cycle of the wait state and only then; masks are taken only in a cycle where `mask_ready_o` and `mask_valid_i` are both high, and the block stays in the wait state while `mask_valid_i` is low.
- R2: On acceptance in vector mode, the source step moves only when source zeroing is off, the source step is below the vector length, and bit `src_step_o` of the source mask (bit 0 = element 0) is clear.
- R3: The destination step obeys the same rule with the destination mask, zeroing flag and step, decided without regard to the source operand.
- R4: A moving step takes the index of the lowest set mask bit strictly above it and strictly below the vector length; if there is none it takes the vector length itself. Mask bits at or above the vector length are ignored.
- R5: If either step moves, `redecode_o` is high in the acceptance cycle, `exec_valid_o` is not raised, and the block returns to idle.
- R6: If no step moves, `exec_valid_o` rises the cycle after acceptance and stays high until a cycle with `exec_ready_i` high, after which the block is idle.
- R7: With `vec_mode_i` low at acceptance, or with an operand's zeroing flag high, that operand's step is unchanged and (if nothing else moves) execution follows.
- R8: Step changes appear on `src_step_o`/`dst_step_o` one clock after the deciding cycle; a reset clears both steps to 0 and leaves the block idle with all handshake outputs low.
- R9: `src_done_o` / `dst_done_o` are high exactly when the corresponding step equals `vl_i`, including the case `vl_i` = 0.
- R10: `step_ld_i` loads `src_ld_val_i` and `dst_ld_val_i` into the steps only while idle; it is ignored in the wait and execute states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start preparing an element (sampled while idle) |
| vec_mode_i | input | 1 | Vector mode; low means scalar, no skipping |
| src_zero_i | input | 1 | Source zeroing mode, disables source skipping |
| dst_zero_i | input | 1 | Destination zeroing mode, disables destination skipping |
| vl_i | input | 7 | Vector length, 0 to 64 |
| step_ld_i | input | 1 | Load both steps (honoured only while idle) |
| src_ld_val_i | input | 7 | Source step value to load |
| dst_ld_val_i | input | 7 | Destination step value to load |
| mask_valid_i | input | 1 | Masks are present |
| src_mask_i | input | 64 | Source predicate mask, bit i enables element i |
| dst_mask_i | input | 64 | Destination predicate mask, bit i enables element i |
| mask_ready_o | output | 1 | Block is waiting for masks |
| redecode_o | output | 1 | A step moved; controller must re-decode |
| exec_valid_o | output | 1 | Current element is offered for execution |
| exec_ready_i | input | 1 | Execution accepts the element |
| src_step_o | output | 7 | Current source step |
| dst_step_o | output | 7 | Current destination step |
| src_done_o | output | 1 | Source step equals the vector length |
| dst_done_o | output | 1 | Destination step equals the vector length |

## Verification
The properties take for granted that `vl_i` never exceeds 64 and that it, together with the loaded step values, stays constant while an element is being prepared; steps loaded above the vector length are outside the intended use. The stimulus changes `vl_i` and the loaded steps only through an idle-time load, keeps every vector length within 0 to 64, and drives the handshake inputs only at the falling edge, so the monotonic-step and hold properties see the inputs they assume. Masks are chosen to place enabled bits below, at, just above and beyond the vector length, and at the top element 63.

// File: rtl/skip_pkg.sv
package skip_pkg;

    // Operand slots handled by the step datapath
    localparam int NUM_OPS = 2;
    localparam int OP_SRC  = 0;
    localparam int OP_DST  = 1;

    // Control sequencer states
    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,
        CTL_MASK = 2'd1,
        CTL_EXEC = 2'd2
    } ctl_state_t;

    // Per-operand decision flags produced by the step datapath
    typedef struct packed {
        logic moved;
        logic at_end;
    } op_flags_t;

    // Step counter width able to hold every value from 0 to the element count
    function automatic int step_width(input int elems);
        return $clog2(elems + 1);
    endfunction

endpackage

// File: rtl/lowbit_encoder.sv
module lowbit_encoder #(
    parameter int W  = 65,
    parameter int IW = 7
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o
);
    // Lowest set bit wins; scanning downward lets the last hit be the lowest
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/step_advance_unit.sv
module step_advance_unit
    import skip_pkg::*;
#(
    parameter int MASK_W = 64,
    parameter int STEP_W = step_width(MASK_W)
) (
    input  logic [MASK_W-1:0] mask_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [STEP_W-1:0] vl_i,
    input  logic              zero_i,
    output logic [STEP_W-1:0] next_o,
    output op_flags_t         flags_o
);
    localparam int CAND_W = MASK_W + 1;

    logic [CAND_W-1:0] cand;
    logic [STEP_W-1:0] found_idx;
    logic              cur_enabled;
    logic              below_len;
    logic              do_skip;

    // Candidate vector: enabled elements in [step, vl), plus a sentinel at vl
    // so the search always lands somewhere.
    always_comb begin
        for (int i = 0; i < MASK_W; i++) begin
            cand[i] = (STEP_W'(i) == vl_i) ||
                      (mask_i[i] && (STEP_W'(i) >= step_i) && (STEP_W'(i) < vl_i));
        end
        cand[MASK_W] = (vl_i == STEP_W'(MASK_W));
    end

    lowbit_encoder #(
        .W  (CAND_W),
        .IW (STEP_W)
    ) u_enc (
        .vec_i (cand),
        .idx_o (found_idx)
    );

    assign cur_enabled = |(mask_i & (MASK_W'(1) << step_i));
    assign below_len   = (step_i < vl_i);
    assign do_skip     = !zero_i && below_len && !cur_enabled;

    assign next_o         = do_skip ? found_idx : step_i;
    assign flags_o.moved  = do_skip;
    assign flags_o.at_end = (step_i == vl_i);
endmodule

// File: rtl/skip_ctrl_fsm.sv
module skip_ctrl_fsm
    import skip_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic mask_valid_i,
    input  logic exec_ready_i,
    input  logic change_i,
    output logic mask_ready_o,
    output logic accept_o,
    output logic redecode_o,
    output logic exec_valid_o,
    output logic idle_o
);
    ctl_state_t state_q, state_d;

    always_comb begin
        state_d      = state_q;
        mask_ready_o = 1'b0;
        accept_o     = 1'b0;
        redecode_o   = 1'b0;
        exec_valid_o = 1'b0;
        unique case (state_q)
            CTL_IDLE: begin
                if (go_i) state_d = CTL_MASK;
            end
            CTL_MASK: begin
                mask_ready_o = 1'b1;
                if (mask_valid_i) begin
                    accept_o = 1'b1;
                    if (change_i) begin
                        redecode_o = 1'b1;
                        state_d    = CTL_IDLE;
                    end else begin
                        state_d    = CTL_EXEC;
                    end
                end
            end
            CTL_EXEC: begin
                exec_valid_o = 1'b1;
                if (exec_ready_i) state_d = CTL_IDLE;
            end
            default: state_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CTL_IDLE;
        else     state_q <= state_d;
    end

    assign idle_o = (state_q == CTL_IDLE);
endmodule

// File: rtl/predicated_step_skipper.sv
module predicated_step_skipper
    import skip_pkg::*;
#(
    parameter  int MASK_W = 64,
    localparam int STEP_W = step_width(MASK_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  logic              vec_mode_i,
    input  logic              src_zero_i,
    input  logic              dst_zero_i,
    input  logic [STEP_W-1:0] vl_i,
    input  logic              step_ld_i,
    input  logic [STEP_W-1:0] src_ld_val_i,
    input  logic [STEP_W-1:0] dst_ld_val_i,
    input  logic              mask_valid_i,
    input  logic [MASK_W-1:0] src_mask_i,
    input  logic [MASK_W-1:0] dst_mask_i,
    output logic              mask_ready_o,
    output logic              redecode_o,
    output logic              exec_valid_o,
    input  logic              exec_ready_i,
    output logic [STEP_W-1:0] src_step_o,
    output logic [STEP_W-1:0] dst_step_o,
    output logic              src_done_o,
    output logic              dst_done_o
);
    logic [NUM_OPS-1:0][MASK_W-1:0] op_mask;
    logic [NUM_OPS-1:0]             op_zero;
    logic [NUM_OPS-1:0][STEP_W-1:0] op_ld;
    logic [NUM_OPS-1:0][STEP_W-1:0] step_q;
    logic [NUM_OPS-1:0][STEP_W-1:0] step_nx;
    op_flags_t [NUM_OPS-1:0]        op_flags;
    logic [NUM_OPS-1:0]             op_moved;

    logic any_change;
    logic accept;
    logic idle;

    assign op_mask[OP_SRC] = src_mask_i;
    assign op_mask[OP_DST] = dst_mask_i;
    assign op_zero[OP_SRC] = src_zero_i;
    assign op_zero[OP_DST] = dst_zero_i;
    assign op_ld[OP_SRC]   = src_ld_val_i;
    assign op_ld[OP_DST]   = dst_ld_val_i;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        step_advance_unit #(
            .MASK_W (MASK_W),
            .STEP_W (STEP_W)
        ) u_adv (
            .mask_i  (op_mask[g]),
            .step_i  (step_q[g]),
            .vl_i    (vl_i),
            .zero_i  (op_zero[g]),
            .next_o  (step_nx[g]),
            .flags_o (op_flags[g])
        );

        assign op_moved[g] = op_flags[g].moved;

        always_ff @(posedge clk) begin
            if (rst) begin
                step_q[g] <= '0;
            end else if (accept && vec_mode_i) begin
                step_q[g] <= step_nx[g];
            end else if (idle && step_ld_i) begin
                step_q[g] <= op_ld[g];
            end
        end
    end

    assign any_change = vec_mode_i && (|op_moved);

    skip_ctrl_fsm u_ctl (
        .clk          (clk),
        .rst          (rst),
        .go_i         (go_i),
        .mask_valid_i (mask_valid_i),
        .exec_ready_i (exec_ready_i),
        .change_i     (any_change),
        .mask_ready_o (mask_ready_o),
        .accept_o     (accept),
        .redecode_o   (redecode_o),
        .exec_valid_o (exec_valid_o),
        .idle_o       (idle)
    );

    assign src_step_o = step_q[OP_SRC];
    assign dst_step_o = step_q[OP_DST];
    assign src_done_o = op_flags[OP_SRC].at_end;
    assign dst_done_o = op_flags[OP_DST].at_end;
endmodule

// File: rtl/predicated_step_skipper_chk.sv
module predicated_step_skipper_chk #(
    parameter  int MASK_W = 64,
    localparam int STEP_W = $clog2(MASK_W + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              vec_mode_i,
    input logic              step_ld_i,
    input logic              mask_valid_i,
    input logic              mask_ready_o,
    input logic              redecode_o,
    input logic              exec_valid_o,
    input logic              exec_ready_i,
    input logic [STEP_W-1:0] src_step_o,
    input logic [STEP_W-1:0] dst_step_o
);
    // R1
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mask_ready_o && exec_valid_o));

    // R5
    redecode_ctx_chk: assert property (@(posedge clk) disable iff (rst)
        redecode_o |-> (mask_ready_o && mask_valid_i && vec_mode_i));

    // R5
    redecode_exit_chk: assert property (@(posedge clk) disable iff (rst)
        redecode_o |=> (!exec_valid_o && !mask_ready_o));

    // R2
    redecode_moves_chk: assert property (@(posedge clk) disable iff (rst)
        redecode_o |=> ((src_step_o != $past(src_step_o)) || (dst_step_o != $past(dst_step_o))));

    // R6
    exec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_valid_o && !exec_ready_i) |=> exec_valid_o);

    // R7
    scalar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_ready_o && mask_valid_i && !vec_mode_i) |=> ($stable(src_step_o) && $stable(dst_step_o)));

    // R4
    step_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_ready_o && mask_valid_i) |=> ((src_step_o >= $past(src_step_o)) && (dst_step_o >= $past(dst_step_o))));

    // R10
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(mask_ready_o && mask_valid_i) && !(step_ld_i && !mask_ready_o && !exec_valid_o))
            |=> ($stable(src_step_o) && $stable(dst_step_o)));
endmodule

bind predicated_step_skipper predicated_step_skipper_chk #(.MASK_W(MASK_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .vec_mode_i   (vec_mode_i),
    .step_ld_i    (step_ld_i),
    .mask_valid_i (mask_valid_i),
    .mask_ready_o (mask_ready_o),
    .redecode_o   (redecode_o),
    .exec_valid_o (exec_valid_o),
    .exec_ready_i (exec_ready_i),
    .src_step_o   (src_step_o),
    .dst_step_o   (dst_step_o)
);

// File: tb/predicated_step_skipper_test.sv
module predicated_step_skipper_test;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 64;
    localparam int SW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          go_i = 1'b0, vec_mode_i = 1'b0, src_zero_i = 1'b0, dst_zero_i = 1'b0;
    logic [SW-1:0] vl_i = '0, src_ld_val_i = '0, dst_ld_val_i = '0;
    logic          step_ld_i = 1'b0, mask_valid_i = 1'b0, exec_ready_i = 1'b0;
    logic [MW-1:0] src_mask_i = '0, dst_mask_i = '0;
    logic          mask_ready_o, redecode_o, exec_valid_o, src_done_o, dst_done_o;
    logic [SW-1:0] src_step_o, dst_step_o;

    predicated_step_skipper #(.MASK_W(MW)) uut (
        .clk(clk), .rst(rst), .go_i(go_i), .vec_mode_i(vec_mode_i),
        .src_zero_i(src_zero_i), .dst_zero_i(dst_zero_i), .vl_i(vl_i),
        .step_ld_i(step_ld_i), .src_ld_val_i(src_ld_val_i), .dst_ld_val_i(dst_ld_val_i),
        .mask_valid_i(mask_valid_i), .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
        .mask_ready_o(mask_ready_o), .redecode_o(redecode_o), .exec_valid_o(exec_valid_o),
        .exec_ready_i(exec_ready_i), .src_step_o(src_step_o), .dst_step_o(dst_step_o),
        .src_done_o(src_done_o), .dst_done_o(dst_done_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [SW-1:0] s;
        logic [SW-1:0] d;
        logic          rd;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;
    logic [SW-1:0] cur_s = '0, cur_d = '0;

    task automatic chk(input string req, input string what, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Independent reference: walk upward from the current step
    function automatic logic [SW-1:0] ref_next(input logic [MW-1:0] m, input logic [SW-1:0] st,
                                               input logic [SW-1:0] vl, input logic zero);
        if (zero || st >= vl || m[st[5:0]]) return st;
        for (int i = int'(st) + 1; i < int'(vl); i++) begin
            if (m[i]) return SW'(i);
        end
        return vl;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Driver: one element preparation; pushes the expected result
    task automatic run_case(input string tag, input logic ld, input logic [SW-1:0] vl,
                            input logic [SW-1:0] s0, input logic [SW-1:0] d0,
                            input logic vec, input logic sz, input logic dz,
                            input logic [MW-1:0] sm, input logic [MW-1:0] dm, input int waits);
        exp_t e;
        logic [SW-1:0] ns, nd;
        @(negedge clk);
        if (ld) begin
            step_ld_i = 1'b1; src_ld_val_i = s0; dst_ld_val_i = d0; vl_i = vl;
            cur_s = s0; cur_d = d0;
            @(negedge clk);
            step_ld_i = 1'b0;
        end
        go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
        for (int w = 0; w < waits; w++) begin
            step_ld_i = 1'b1; src_ld_val_i = 7'd33; dst_ld_val_i = 7'd34;
            #(CLK_PERIOD / 4);
            chk("R1", {tag, " mask_ready while waiting"}, mask_ready_o, 1);
            @(negedge clk);
        end
        step_ld_i = 1'b0;
        vec_mode_i = vec; src_zero_i = sz; dst_zero_i = dz;
        src_mask_i = sm; dst_mask_i = dm; mask_valid_i = 1'b1;
        ns = vec ? ref_next(sm, cur_s, vl_i, sz) : cur_s;
        nd = vec ? ref_next(dm, cur_d, vl_i, dz) : cur_d;
        e.s = ns; e.d = nd; e.rd = (ns != cur_s) || (nd != cur_d);
        exp_q.push_back(e);
        cur_s = ns; cur_d = nd;
        @(negedge clk);
        mask_valid_i = 1'b0;
        #(CLK_PERIOD / 4);
        if (e.rd) begin
            chk("R5", {tag, " no exec after redecode"}, exec_valid_o, 0);
            chk("R5", {tag, " idle after redecode"}, mask_ready_o, 0);
        end else begin
            chk("R6", {tag, " exec offered"}, exec_valid_o, 1);
            @(negedge clk);
            #(CLK_PERIOD / 4);
            chk("R6", {tag, " exec held without ready"}, exec_valid_o, 1);
            @(negedge clk);
            exec_ready_i = 1'b1;
            @(negedge clk);
            exec_ready_i = 1'b0;
            #(CLK_PERIOD / 4);
            chk("R6", {tag, " exec released"}, exec_valid_o, 0);
        end
    endtask

    // Monitor: captures redecode at acceptance, compares steps one clock later (R8)
    initial begin
        bit   pending = 0;
        logic cap_rd = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD / 4);
            if (!rst) begin
                if (pending) begin
                    pending = 0;
                    if (exp_q.size() == 0) begin
                        chk("R8", "scoreboard underflow", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk("R2", "source step", src_step_o, e.s);
                        chk("R3", "destination step", dst_step_o, e.d);
                        chk("R5", "redecode flag", cap_rd, e.rd);
                        chk("R9", "source done", src_done_o, e.s == vl_i);
                        chk("R9", "destination done", dst_done_o, e.d == vl_i);
                    end
                end
                if (mask_ready_o && mask_valid_i) begin
                    cap_rd = redecode_o;
                    pending = 1;
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #(CLK_PERIOD / 4);
        chk("R8", "reset src step", src_step_o, 0);
        chk("R8", "reset dst step", dst_step_o, 0);
        chk("R8", "reset mask_ready", mask_ready_o, 0);
        chk("R8", "reset exec_valid", exec_valid_o, 0);
        chk("R8", "reset redecode", redecode_o, 0);

        // R2/R10: source skips to element 4; loads poked while waiting are ignored
        run_case("R10 skip", 1, 7'd8, 7'd0, 7'd0, 1, 0, 0, 64'hF0, 64'h1, 2);
        // R6: repeated without reload, both bits enabled, execution follows
        run_case("R6 stay", 0, 7'd8, 7'd0, 7'd0, 1, 0, 0, 64'hF0, 64'h1, 0);
        // R4: empty masks clamp both to vector length
        run_case("R4 clamp", 1, 7'd8, 7'd2, 7'd3, 1, 0, 0, 64'h0, 64'h0, 0);
        // R4: enabled bit beyond vector length is ignored
        run_case("R4 beyond", 1, 7'd5, 7'd1, 7'd4, 1, 0, 0, 64'h40, 64'h10, 1);
        // R7/R3: source zeroing holds source while destination skips alone
        run_case("R7 zero", 1, 7'd20, 7'd1, 7'd2, 1, 1, 0, 64'h0, 64'h400, 0);
        // R3: destination zeroing, source skips
        run_case("R3 dzero", 1, 7'd20, 7'd1, 7'd2, 1, 0, 1, 64'h100, 64'h0, 0);
        // R7: scalar mode never moves steps
        run_case("R7 scalar", 1, 7'd16, 7'd3, 7'd5, 0, 0, 0, 64'h0, 64'h0, 0);
        // R4/R9: full length, top element and end of vector
        run_case("R9 top", 1, 7'd64, 7'd60, 7'd63, 1, 0, 0, 64'h8000_0000_0000_0000, 64'h0, 0);
        // R9: zero-length vector, nothing moves, both done
        run_case("R9 empty", 1, 7'd0, 7'd0, 7'd0, 1, 0, 0, 64'h0, 64'h0, 0);
        // R2: step already at vector length does not move
        run_case("R2 atend", 1, 7'd10, 7'd10, 7'd9, 1, 0, 0, 64'h0, 64'h0, 0);

        repeat (3) @(negedge clk);
        chk("R8", "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule